// File: doc/BRIEF.md
# Two-Digit Decimal Cascade Counter

This block counts from 00 to 99 in binary-coded decimal and then starts again at 00. It is built from two identical decade stages that share one clock. Each stage works out its next state from per-bit toggle conditions, not from an adder. The low stage steps on every clock edge while the global enable is high. Its terminal-count output drives the count enable of the high stage, so the high stage steps only on the edge where the low stage rolls from 9 to 0.

Each stage raises a terminal-count flag. Two registered one-cycle pulses mark every tenth and every hundredth counted edge. These pulses act as divide-by-10 and divide-by-100 outputs of the counted clock. A synchronous reset clears the whole chain.

Top module: `bcd_cascade_counter`

## Requirements
- R1: While `rst` is high at a clock edge, both digits become 0000 and both pulse outputs become 0 on that edge, whatever the value of `en`.
- R2: With `en` high, the low digit steps by one on each clock edge (0,1,...,9) and goes from 9 back to 0.
- R3: Each digit is a 4-bit BCD value (bit 3 is the most significant bit) and never holds a value above 9.
- R4: `tc_lo` is high exactly when `en` is high and the low digit equals 9.
- R5: The high digit steps by one (9 goes back to 0) only on an edge where `tc_lo` is high, and holds on every other edge. `tc_hi` is high exactly when `tc_lo` is high and the high digit equals 9.
- R6: With `en` low, both digits hold their values, and `tc_lo` and `tc_hi` are both low.
- R7: `div10_pulse` is high for exactly the one clock cycle that follows an edge on which the low digit wrapped from 9 to 0, and is low at all other times.
- R8: `div100_pulse` is high for exactly the one clock cycle that follows an edge on which the count wrapped from 99 to 00, and is low at all other times.
- R9: Starting from any value, 100 enabled clock edges bring the counter back to that same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both stages |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global count enable for the low stage |
| digit_lo | output | 4 | Units digit, BCD |
| digit_hi | output | 4 | Tens digit, BCD |
| tc_lo | output | 1 | Terminal count of the low stage; count enable of the high stage |
| tc_hi | output | 1 | Terminal count of the high stage |
| div10_pulse | output | 1 | Registered pulse, once per ten counted edges |
| div100_pulse | output | 1 | Registered pulse, once per hundred counted edges |

## Verification
The hardest situation to reach from the ports is the wrap from 99 to 00. At that edge both stages roll over together and both pulses must appear one cycle later. Getting there takes 99 enabled edges, so the bench runs the counter to 99 with `en` held high. It then checks the wrap and the cycle after it. It also parks the count at 99 and at 09 with `en` low, to show that the terminal counts stay low when the enable is removed, even though the digits sit at their terminal values. The bench also asserts reset while `en` is high at 99, to show that the clear wins over the pending wrap.

// File: rtl/bcd_cascade_pkg.sv
package bcd_cascade_pkg;
    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t val;
    } digit_state_t;

    typedef struct packed {
        logic div10;
        logic div100;
    } pulse_state_t;
endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
    import bcd_cascade_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cnt_en,
    output digit_t q,
    output logic   tc
);
    digit_state_t st_d, st_q;
    digit_t       tog;

    always_comb begin
        digit_t v;
        v      = st_q.val;
        tog[0] = 1'b1;
        tog[1] = v[0] & ~v[3];
        tog[2] = v[1] & v[0];
        tog[3] = (v[2] & v[1] & v[0]) | (v[3] & v[0]);
        st_d   = st_q;
        if (rst) begin
            st_d.val = '0;
        end else if (cnt_en) begin
            st_d.val = v ^ tog;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q  = st_q.val;
    assign tc = cnt_en && (st_q.val == digit_t'(DIGIT_MAX));

    // R1: a clear wins over counting
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> q == '0);
    // R3: the digit stays a valid BCD value
    a_r3_bcd_range: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> q <= digit_t'(DIGIT_MAX));
    // R2: step by one below 9
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && q != digit_t'(DIGIT_MAX)) |=> q == $past(q) + 1'b1);
    // R2: wrap after terminal count
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        tc |=> q == '0);
    // R6: hold while disabled
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(q));
endmodule

// File: rtl/bcd_cascade_counter.sv
module bcd_cascade_counter
    import bcd_cascade_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [3:0] digit_lo,
    output logic [3:0] digit_hi,
    output logic       tc_lo,
    output logic       tc_hi,
    output logic       div10_pulse,
    output logic       div100_pulse
);
    localparam int NUM_STAGES = 2;

    logic   stage_en [NUM_STAGES];
    logic   stage_tc [NUM_STAGES];
    digit_t stage_q  [NUM_STAGES];

    assign stage_en[0] = en;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        bcd_digit_stage u_digit (
            .clk    (clk),
            .rst    (rst),
            .cnt_en (stage_en[i]),
            .q      (stage_q[i]),
            .tc     (stage_tc[i])
        );
        if (i + 1 < NUM_STAGES) begin : g_link
            assign stage_en[i+1] = stage_tc[i];
        end
    end

    pulse_state_t pl_d, pl_q;

    always_comb begin
        pl_d = '0;
        if (!rst) begin
            pl_d.div10  = stage_tc[0];
            pl_d.div100 = stage_tc[NUM_STAGES-1];
        end
    end

    always_ff @(posedge clk) begin
        pl_q <= pl_d;
    end

    assign digit_lo     = stage_q[0];
    assign digit_hi     = stage_q[1];
    assign tc_lo        = stage_tc[0];
    assign tc_hi        = stage_tc[1];
    assign div10_pulse  = pl_q.div10;
    assign div100_pulse = pl_q.div100;

    // R5: the tens stage can only end a cycle when the units stage does
    a_r5_tc_chain: assert property (@(posedge clk) disable iff (rst) tc_hi |-> tc_lo);
    // R5: the tens digit holds when the units stage does not carry
    a_r5_hi_hold: assert property (@(posedge clk) disable iff (rst)
        !tc_lo |=> $stable(digit_hi));
    // R6: no terminal count while disabled
    a_r6_no_tc: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tc_lo && !tc_hi);
    // R7: the divide-by-10 pulse follows a units wrap
    a_r7_div10_after_wrap: assert property (@(posedge clk) disable iff (rst)
        div10_pulse |-> digit_lo == '0);
    // R8: the divide-by-100 pulse coincides with a divide-by-10 pulse at 00
    a_r8_div100_nested: assert property (@(posedge clk) disable iff (rst)
        div100_pulse |-> div10_pulse && digit_hi == '0);
endmodule

// File: tb/bcd_cascade_counter_bench.sv
module bcd_cascade_counter_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] digit_lo, digit_hi;
    logic       tc_lo, tc_hi, div10_pulse, div100_pulse;

    int checks = 0;
    int errors = 0;
    int ev     = 0;
    bit e10    = 0;
    bit e100   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_cascade_counter u_bcd_cascade_counter (
        .clk(clk), .rst(rst), .en(en),
        .digit_lo(digit_lo), .digit_hi(digit_hi),
        .tc_lo(tc_lo), .tc_hi(tc_hi),
        .div10_pulse(div10_pulse), .div100_pulse(div100_pulse)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // check the combinational terminal counts before an edge
    task automatic check_tc();
        chk("R4 tc_lo", int'(tc_lo), int'(en && (ev % 10 == 9) && !rst));
        chk("R5 tc_hi", int'(tc_hi), int'(en && ev == 99 && !rst));
    endtask

    // check the registered state after an edge
    task automatic check_state();
        chk("R2 digit_lo", int'(digit_lo), ev % 10);
        chk("R5 digit_hi", int'(digit_hi), ev / 10);
        chk("R3 lo range", int'(digit_lo <= 4'd9), 1);
        chk("R7 div10", int'(div10_pulse), int'(e10));
        chk("R8 div100", int'(div100_pulse), int'(e100));
    endtask

    // one clock edge with inputs driven at the falling edge
    task automatic step(bit r, bit e);
        rst = r;
        en  = e;
        #1;
        if (!r) check_tc();
        @(posedge clk);
        if (r) begin
            ev = 0; e10 = 0; e100 = 0;
        end else if (e) begin
            e10  = (ev % 10 == 9);
            e100 = (ev == 99);
            ev   = (ev + 1) % 100;
        end else begin
            e10 = 0; e100 = 0;
        end
        @(negedge clk);
        check_state();
    endtask

    task automatic t_reset();
        step(1, 0);
        chk("R1 reset lo", int'(digit_lo), 0);
        chk("R1 reset hi", int'(digit_hi), 0);
    endtask

    task automatic t_units_run();
        for (int i = 0; i < 23; i++) step(0, 1);
        chk("R2 at 23", int'(digit_lo) + 10 * int'(digit_hi), 23);
    endtask

    task automatic t_hold_patterns();
        while (ev != 9) step(0, 1);
        for (int i = 0; i < 3; i++) step(0, 0);
        chk("R6 hold at 09", int'(digit_lo), 9);
        chk("R6 no tc_lo at 09", int'(tc_lo), 0);
        for (int i = 0; i < 8; i++) step(0, (i % 2) == 0);
    endtask

    task automatic t_full_wrap();
        while (ev != 99) step(0, 1);
        step(0, 0);
        chk("R6 no tc_hi at 99", int'(tc_hi), 0);
        step(0, 1);
        chk("R8 wrap to 00", int'(digit_hi) * 10 + int'(digit_lo), 0);
        chk("R8 div100 after wrap", int'(div100_pulse), 1);
        step(0, 1);
        chk("R8 div100 single cycle", int'(div100_pulse), 0);
    endtask

    task automatic t_reset_priority();
        while (ev != 99) step(0, 1);
        step(1, 1);
        chk("R1 reset beats wrap div100", int'(div100_pulse), 0);
        chk("R1 reset beats count", int'(digit_lo), 0);
    endtask

    task automatic t_cycle_100();
        int start;
        for (int i = 0; i < 37; i++) step(0, 1);
        start = int'(digit_hi) * 10 + int'(digit_lo);
        for (int i = 0; i < 100; i++) step(0, 1);
        chk("R9 period 100", int'(digit_hi) * 10 + int'(digit_lo), start);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_units_run();
        t_hold_patterns();
        t_full_wrap();
        t_reset_priority();
        t_cycle_100();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule